// File: doc/BRIEF.md
# Scatter-Gather Playback DMA Channel

This block is one DMA channel that streams audio data from memory into a small local word FIFO. Software writes the address of a table of 8-byte descriptors into a base register and issues a start command. The channel then fetches each descriptor, reads the buffer it points to one 32-bit word at a time, and pushes those words into the FIFO. A sample consumer drains the FIFO through a pop port.

Per-descriptor flags can hold the channel at the end of a block (STOP), hold it and raise a flag (FLAG), or mark the last entry of the table (EOL). At the end of the table the channel either goes idle or returns to the table base. It returns to the base when the auto-restart bit is set or when a start command was queued while the channel was running. Software pauses or kills the channel through a control byte. A level interrupt follows the enabled status flags.

Memory is read through a request/acknowledge port with one request outstanding at a time. Registers are byte-wide, and each is written in one cycle.

Top module: `sgd_channel`

## Requirements
- R1: After reset the status byte reads 0x00, `irq` is low, `mem_req` is low and `fifo_valid` is low.
- R2: A control write (register address 1) with bit 7 set, issued while status bit 7 (active) is clear, sets active and clears status bits 6 (paused) and 2 (halted). It then fetches the descriptor table starting at the base (address registers 4..7, little-endian) with bit 0 forced to 0. The low descriptor word comes first and gives the buffer address. The high word comes second: bits 23:0 are the byte count, bit 29 STOP, bit 30 FLAG and bit 31 EOL.
- R3: Memory requests start only while (status AND 0xC4) equals 0x80. A control write sets paused (status bit 6) from its bit 2, and that write halts new reads. A later control write with bit 2 clear resumes the transfer at the next word.
- R4: Each data read fetches the 32-bit word at the current buffer address, then adds 4 to the address and subtracts 4 from the count. A block with byte count N produces max(1, ceil(N/4)) words, because the block ends once the count reaches zero or below.
- R5: At each block end the descriptor pointer (readable at addresses 8..11) advances by 8, and the next descriptor is fetched from there.
- R6: A block ending with STOP sets status bit 2. A block ending with FLAG sets status bits 2 and 0. Either one halts transfers while active stays set.
- R7: A block ending with EOL sets status bit 1. If status bit 3 (trigger queued) or type bit 7 (auto-restart, register address 2) is set, bit 3 is cleared and the fetch restarts at the table base. Otherwise active is cleared.
- R8: A control write with bit 7 set while active is already set only sets status bit 3.
- R9: A control write with bit 6 set clears status bits 7 and 3.
- R10: Writing the status register (address 0) clears each of bits 2..0 that is written as 1. Bits 7..3 are not changed by such a write.
- R11: `irq` is high exactly when (status bits 1:0) AND (type bits 1:0) is non-zero.
- R12: The FIFO holds 8 words. A data read starts only while a word is free. Words leave the FIFO in the order they were read.
- R13: Once `mem_req` is raised, it and `mem_addr` hold steady until the cycle `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge, with mem_rdata valid |
| mem_rdata | input | 32 | Read data |
| fifo_pop | input | 1 | Consumer removes the head word |
| fifo_valid | output | 1 | FIFO holds at least one word |
| fifo_data | output | 32 | Head word of the FIFO |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps block byte counts across the word boundaries: 0, 1, 3, 4, 5, 8, 12 and 17. An off-by-one in the end test there would drop or add a word. It sends a start both while the channel is idle and while it is running. A design that treated the second start as a fresh start would rewind the table mid-block instead of replaying it once after EOL. It lets the FIFO fill with no consumer: an overrun would lose or reorder words, and a channel that ignored the pause bit would keep issuing reads. It also clears the halted and flag bits one at a time. This exposes an interrupt that does not follow the enables, and a write-one-to-clear that reaches the control bits.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE    = 2'd0,
        ENG_DESC_LO = 2'd1,
        ENG_DESC_HI = 2'd2,
        ENG_DATA    = 2'd3
    } eng_state_e;

    // status bit positions
    localparam int unsigned ST_ACTIVE = 7;
    localparam int unsigned ST_PAUSED = 6;
    localparam int unsigned ST_TRIGQ  = 3;
    localparam int unsigned ST_HALT   = 2;
    localparam int unsigned ST_EOL    = 1;
    localparam int unsigned ST_FLAG   = 0;

    localparam logic [7:0] RUN_MASK  = 8'hC4;
    localparam logic [7:0] RUN_VALUE = 8'h80;
    localparam logic [7:0] W1C_MASK  = 8'h07;
    localparam logic [7:0] TYPE_MASK = 8'h83;

    // register byte addresses
    localparam logic [3:0] RA_STATUS = 4'd0;
    localparam logic [3:0] RA_CTRL   = 4'd1;
    localparam logic [3:0] RA_TYPE   = 4'd2;

    typedef struct packed {
        logic eol;
        logic flag;
        logic stop;
    } blk_flags_t;

endpackage

// File: rtl/sgd_fifo.sv
module sgd_fifo #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic          room_o,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]   wr;
        logic [PW-1:0]   rd;
        logic [CNTW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [DW-1:0] store_q [DEPTH];
    logic          pop_ok;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d      = q;
        pop_ok = pop_i && (q.cnt != '0);
        if (push_i) d.wr = wrap_inc(q.wr);
        if (pop_ok) d.rd = wrap_inc(q.rd);
        case ({push_i, pop_ok})
            2'b10:   d.cnt = q.cnt + CNTW'(1);
            2'b01:   d.cnt = q.cnt - CNTW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_i) store_q[q.wr] <= push_data_i;
    end

    assign room_o  = (q.cnt < CNTW'(DEPTH));
    assign valid_o = (q.cnt != '0);
    assign data_o  = store_q[q.rd];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (q.cnt < CNTW'(DEPTH)) || (pop_i && q.cnt != '0)); // R12

endmodule

// File: rtl/sgd_engine.sv
module sgd_engine
    import sgd_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          reload_i,
    input  logic [AW-1:0] base_i,
    input  logic          room_i,
    input  logic          mem_ack_i,
    input  logic [31:0]   mem_rdata_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          push_o,
    output logic [31:0]   push_data_o,
    output logic          blk_end_o,
    output blk_flags_t    blk_flags_o,
    output logic [AW-1:0] ptr_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [AW-1:0] WORD_STEP = AW'(4);
    localparam logic [AW-1:0] DESC_STEP = AW'(8);
    localparam logic [CW-1:0] CNT_STEP  = CW'(4);

    typedef struct packed {
        eng_state_e    state;
        logic [AW-1:0] ptr;
        logic [AW-1:0] buf_addr;
        logic [CW-1:0] cnt;
        blk_flags_t    flags;
        logic          have_desc;
        logic          reload_pend;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d           = q;
        mem_req_o   = 1'b0;
        mem_addr_o  = q.ptr;
        push_o      = 1'b0;
        blk_end_o   = 1'b0;
        d.reload_pend = q.reload_pend | reload_i;
        unique case (q.state)
            ENG_IDLE: begin
                if (q.reload_pend || reload_i) begin
                    d.ptr         = {base_i[AW-1:1], 1'b0};
                    d.have_desc   = 1'b0;
                    d.reload_pend = 1'b0;
                end else if (run_i) begin
                    if (!q.have_desc)  d.state = ENG_DESC_LO;
                    else if (room_i)   d.state = ENG_DATA;
                end
            end
            ENG_DESC_LO: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.ptr;
                if (mem_ack_i) begin
                    d.buf_addr = mem_rdata_i[AW-1:0];
                    d.state    = ENG_DESC_HI;
                end
            end
            ENG_DESC_HI: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.ptr + WORD_STEP;
                if (mem_ack_i) begin
                    d.cnt       = mem_rdata_i[CW-1:0];
                    d.flags     = mem_rdata_i[31:29];
                    d.have_desc = 1'b1;
                    d.state     = ENG_IDLE;
                end
            end
            ENG_DATA: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.buf_addr;
                if (mem_ack_i) begin
                    push_o     = 1'b1;
                    d.buf_addr = q.buf_addr + WORD_STEP;
                    d.state    = ENG_IDLE;
                    if (q.cnt <= CNT_STEP) begin
                        d.cnt       = '0;
                        d.ptr       = q.ptr + DESC_STEP;
                        d.have_desc = 1'b0;
                        blk_end_o   = 1'b1;
                    end else begin
                        d.cnt = q.cnt - CNT_STEP;
                    end
                end
            end
            default: d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ENG_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push_data_o = mem_rdata_i;
    assign blk_flags_o = q.flags;
    assign ptr_o       = q.ptr;
    assign cnt_o       = q.cnt;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R13

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end_o |=> (ptr_o == $past(ptr_o) + DESC_STEP)); // R5

    AST_ISSUE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> $past(run_i)); // R3

endmodule

// File: rtl/sgd_regs.sv
module sgd_regs
    import sgd_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [3:0]    addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o,
    input  logic          blk_end_i,
    input  blk_flags_t    blk_flags_i,
    input  logic [AW-1:0] ptr_i,
    input  logic [CW-1:0] cnt_i,
    output logic          run_o,
    output logic          reload_o,
    output logic [AW-1:0] base_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [7:0]  status;
        logic [7:0]  ctype;
        logic [31:0] base;
        logic        reload;
    } regs_t;

    regs_t q, d;
    logic [7:0]  st;
    logic [31:0] ptr_w;
    logic [31:0] cnt_w;

    always_comb begin
        d        = q;
        d.reload = 1'b0;
        st       = q.status;
        // block-end effects come first, a same-cycle software write wins
        if (blk_end_i) begin
            if (blk_flags_i.stop) st[ST_HALT] = 1'b1;
            if (blk_flags_i.flag) begin
                st[ST_FLAG] = 1'b1;
                st[ST_HALT] = 1'b1;
            end
            if (blk_flags_i.eol) begin
                st[ST_EOL] = 1'b1;
                if (st[ST_TRIGQ] || q.ctype[7]) begin
                    st[ST_TRIGQ] = 1'b0;
                    d.reload     = 1'b1;
                end else begin
                    st[ST_ACTIVE] = 1'b0;
                end
            end
        end
        if (wr_i) begin
            case (addr_i)
                RA_STATUS: st = st & ~(wdata_i & W1C_MASK);
                RA_CTRL: begin
                    if (wdata_i[7]) begin
                        if (st[ST_ACTIVE]) begin
                            st[ST_TRIGQ] = 1'b1;
                        end else begin
                            st[ST_ACTIVE] = 1'b1;
                            st[ST_PAUSED] = 1'b0;
                            st[ST_HALT]   = 1'b0;
                            d.reload      = 1'b1;
                        end
                    end
                    if (wdata_i[6]) begin
                        st[ST_ACTIVE] = 1'b0;
                        st[ST_TRIGQ]  = 1'b0;
                    end
                    st[ST_PAUSED] = wdata_i[2];
                end
                RA_TYPE: d.ctype = wdata_i & TYPE_MASK;
                4'd4:    d.base[7:0]   = wdata_i;
                4'd5:    d.base[15:8]  = wdata_i;
                4'd6:    d.base[23:16] = wdata_i;
                4'd7:    d.base[31:24] = wdata_i;
                default: ;
            endcase
        end
        d.status = st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ptr_w = 32'(ptr_i);
        cnt_w = 32'(cnt_i);
        case (addr_i)
            RA_STATUS: rdata_o = q.status;
            RA_TYPE:   rdata_o = q.ctype;
            4'd4:      rdata_o = q.base[7:0];
            4'd5:      rdata_o = q.base[15:8];
            4'd6:      rdata_o = q.base[23:16];
            4'd7:      rdata_o = q.base[31:24];
            4'd8:      rdata_o = ptr_w[7:0];
            4'd9:      rdata_o = ptr_w[15:8];
            4'd10:     rdata_o = ptr_w[23:16];
            4'd11:     rdata_o = ptr_w[31:24];
            4'd12:     rdata_o = cnt_w[7:0];
            4'd13:     rdata_o = cnt_w[15:8];
            4'd14:     rdata_o = cnt_w[23:16];
            default:   rdata_o = 8'h00;
        endcase
    end

    assign run_o    = ((q.status & RUN_MASK) == RUN_VALUE);
    assign reload_o = q.reload;
    assign base_o   = q.base[AW-1:0];
    assign irq_o    = |(q.status[1:0] & q.ctype[1:0]);

    AST_START_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_CTRL && wdata_i[7] && !wdata_i[6]) |=> q.status[ST_ACTIVE]); // R2

    AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_CTRL && wdata_i[6]) |=> (!q.status[ST_ACTIVE] && !q.status[ST_TRIGQ])); // R9

    AST_W1C_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_STATUS && !blk_end_i) |=> (q.status[7:3] == $past(q.status[7:3]))); // R10

    AST_FLAG_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end_i && blk_flags_i.flag && q.ctype[0] && !wr_i) |=> irq_o); // R11

endmodule

// File: rtl/sgd_channel.sv
module sgd_channel
    import sgd_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned CW         = 24,
    parameter int unsigned FIFO_WORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic          fifo_pop,
    output logic          fifo_valid,
    output logic [31:0]   fifo_data,
    output logic          irq
);
    logic          run, reload, room, push, blk_end;
    logic [AW-1:0] base, ptr;
    logic [CW-1:0] cnt;
    logic [31:0]   push_data;
    blk_flags_t    blk_flags;

    sgd_regs #(.AW(AW), .CW(CW)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .blk_end_i  (blk_end),
        .blk_flags_i(blk_flags),
        .ptr_i      (ptr),
        .cnt_i      (cnt),
        .run_o      (run),
        .reload_o   (reload),
        .base_o     (base),
        .irq_o      (irq)
    );

    sgd_engine #(.AW(AW), .CW(CW)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .reload_i   (reload),
        .base_i     (base),
        .room_i     (room),
        .mem_ack_i  (mem_ack),
        .mem_rdata_i(mem_rdata),
        .mem_req_o  (mem_req),
        .mem_addr_o (mem_addr),
        .push_o     (push),
        .push_data_o(push_data),
        .blk_end_o  (blk_end),
        .blk_flags_o(blk_flags),
        .ptr_o      (ptr),
        .cnt_o      (cnt)
    );

    sgd_fifo #(.DW(32), .DEPTH(FIFO_WORDS)) i_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .push_data_i(push_data),
        .pop_i      (fifo_pop),
        .room_o     (room),
        .valid_o    (fifo_valid),
        .data_o     (fifo_data)
    );

endmodule

// File: tb/test_sgd_channel.sv
`timescale 1ns/1ps
module test_sgd_channel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        fifo_pop;
    logic        fifo_valid;
    logic [31:0] fifo_data;
    logic        irq;

    int n_vec = 0;
    int n_miss = 0;
    int cyc = 0;

    logic [31:0] desc_mem [64];
    logic [31:0] got [64];
    int          ngot;
    int          n_reads = 0;
    int          n_data = 0;
    int          r13_err = 0;
    logic [31:0] first_addr;
    logic        first_seen;
    logic        busy = 1'b0;
    logic [31:0] hold_addr;
    int          wait_n;

    localparam logic [2:0] F_EOL = 3'b100, F_FLAG = 3'b010, F_STOP = 3'b001;
    localparam int TBL = 16; // table at byte 0x40

    always #2 clk = ~clk;

    sgd_channel i_sgd_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fifo_pop(fifo_pop), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    task automatic summary_and_end();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_vec++; n_miss++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            summary_and_end();
        end
    end

    // memory responder with latency 0..2 negedges, checks R13 hold
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (!busy) begin
                busy = 1'b1; hold_addr = mem_addr; wait_n = n_reads % 3;
                if (!first_seen) begin first_seen = 1'b1; first_addr = mem_addr; end
            end else if (mem_addr != hold_addr) begin
                r13_err++;
                $display("FAIL R13 address moved: actual %h expected %h", mem_addr, hold_addr);
            end
            if (wait_n == 0) begin
                mem_ack = 1'b1;
                mem_rdata = (hold_addr < 32'h100) ? desc_mem[hold_addr[7:2]] : pat(hold_addr);
                if (hold_addr >= 32'h100) n_data++;
                busy = 1'b0; n_reads++;
            end else begin
                wait_n--;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'd0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    task automatic set_desc(input int idx, input logic [31:0] b, input logic [23:0] n,
                            input logic [2:0] f);
        desc_mem[TBL + 2*idx]     = b;
        desc_mem[TBL + 2*idx + 1] = {f, 5'd0, n};
    endtask

    task automatic collect(input int limit);
        int idle = 0;
        int guard = 0;
        reg_addr = 4'd0;
        while (idle < 6 && ngot < limit && ngot < 64 && guard < 5000) begin
            @(negedge clk);
            guard++;
            #0.5;
            if (fifo_valid) begin
                got[ngot] = fifo_data; ngot++; fifo_pop = 1'b1; idle = 0;
            end else begin
                fifo_pop = 1'b0;
                if (!mem_req && ((reg_rdata & 8'hC4) != 8'h80)) idle++;
                else idle = 0;
            end
        end
        @(negedge clk);
        fifo_pop = 1'b0;
    endtask

    task automatic check_seq(input string tag, input int off, input logic [31:0] a, input int n);
        for (int i = 0; i < n; i++) check(tag, got[off + i], pat(a + 32'(4*i)));
    endtask

    logic [7:0]  s;
    logic [31:0] p;
    int          snap;

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        fifo_pop = 1'b0; mem_ack = 1'b0; mem_rdata = '0; first_seen = 1'b0;
        for (int i = 0; i < 64; i++) desc_mem[i] = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, s);
        check("R1 status", 32'(s), 32'h00);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 mem_req", 32'(mem_req), 32'h0);
        check("R1 fifo_valid", 32'(fifo_valid), 32'h0);

        // base 0x41: bit 0 must be ignored
        wr(4'd4, 8'h41); wr(4'd5, 8'h00); wr(4'd6, 8'h00); wr(4'd7, 8'h00);

        // R4 byte-count sweep, single EOL descriptor, R2 fetch address, R7 finish
        foreach (desc_mem[k]) if (k < 0) desc_mem[k] = 0;
        for (int k = 0; k < 8; k++) begin
            int cnts [8] = '{0, 1, 3, 4, 5, 8, 12, 17};
            int nexp;
            logic [31:0] b;
            b = 32'h1000 + 32'(k * 'h100);
            nexp = (cnts[k] <= 4) ? 1 : (cnts[k] + 3) / 4;
            set_desc(0, b, 24'(cnts[k]), F_EOL);
            first_seen = 1'b0; ngot = 0;
            wr(4'd1, 8'h80);
            collect(64);
            check("R2 first descriptor address", first_addr, 32'h40);
            check("R4 word count", 32'(ngot), 32'(nexp));
            check_seq("R4 data sequence", 0, b, nexp);
            rd(4'd0, s);
            check("R7 EOL finish status", 32'(s), 32'h02);
            wr(4'd0, 8'h07);
        end

        // R6 STOP then resume, R5 pointer step, R10 clear halt
        set_desc(0, 32'h2000, 24'd8, F_STOP);
        set_desc(1, 32'h2100, 24'd4, F_EOL);
        ngot = 0;
        wr(4'd1, 8'h80);
        collect(64);
        check("R6 STOP words", 32'(ngot), 32'd2);
        check_seq("R6 STOP data", 0, 32'h2000, 2);
        rd(4'd0, s);
        check("R6 STOP status", 32'(s), 32'h84);
        check("R11 no irq without enable", 32'(irq), 32'h0);
        wr(4'd0, 8'h04);
        ngot = 0;
        collect(64);
        check("R5 next descriptor words", 32'(ngot), 32'd1);
        check_seq("R5 next descriptor data", 0, 32'h2100, 1);
        rd(4'd8, s); p[7:0] = s;  rd(4'd9, s);  p[15:8] = s;
        rd(4'd10, s); p[23:16] = s; rd(4'd11, s); p[31:24] = s;
        check("R5 pointer after two blocks", p, 32'h50);
        rd(4'd0, s);
        check("R7 finish after chain", 32'(s), 32'h02);
        wr(4'd0, 8'h07);

        // R6 FLAG, R11 irq enables, R10 write-one-to-clear
        wr(4'd2, 8'h01);
        set_desc(0, 32'h2200, 24'd4, F_FLAG);
        set_desc(1, 32'h2300, 24'd4, F_EOL);
        ngot = 0;
        wr(4'd1, 8'h80);
        collect(64);
        rd(4'd0, s);
        check("R6 FLAG status", 32'(s), 32'h85);
        check("R11 irq on FLAG", 32'(irq), 32'h1);
        wr(4'd0, 8'h01);
        rd(4'd0, s);
        check("R10 clear FLAG only", 32'(s), 32'h84);
        check("R11 irq dropped", 32'(irq), 32'h0);
        wr(4'd0, 8'h04);
        collect(64);
        check("R6 FLAG chain words", 32'(ngot), 32'd2);
        check_seq("R6 FLAG chain data", 1, 32'h2300, 1);
        rd(4'd0, s);
        check("R7 EOL status after FLAG", 32'(s), 32'h02);
        check("R11 EOL not enabled", 32'(irq), 32'h0);
        wr(4'd2, 8'h02);
        check("R11 EOL enabled", 32'(irq), 32'h1);
        wr(4'd0, 8'hF8);
        rd(4'd0, s);
        check("R10 high bits ignored", 32'(s), 32'h02);
        wr(4'd0, 8'h02);
        check("R11 irq after clear", 32'(irq), 32'h0);
        wr(4'd2, 8'h00);

        // R12 FIFO fill without consumer
        set_desc(0, 32'h3000, 24'd48, F_EOL);
        n_data = 0;
        wr(4'd1, 8'h80);
        repeat (200) @(negedge clk);
        check("R12 reads stop at FIFO depth", 32'(n_data), 32'd8);
        check("R12 no request when full", 32'(mem_req), 32'h0);
        rd(4'd0, s);
        check("R12 still active", 32'(s), 32'h80);
        ngot = 0;
        collect(64);
        check("R12 total words", 32'(ngot), 32'd12);
        check_seq("R12 order", 0, 32'h3000, 12);
        wr(4'd0, 8'h07);

        // R3 pause and resume
        n_data = 0;
        wr(4'd1, 8'h80);
        repeat (3) @(negedge clk);
        wr(4'd1, 8'h04);
        rd(4'd0, s);
        check("R3 paused status", 32'(s), 32'hC0);
        repeat (6) @(negedge clk);
        snap = n_data;
        repeat (30) @(negedge clk);
        check("R3 no reads while paused", 32'(n_data), 32'(snap));
        check("R3 no request while paused", 32'(mem_req), 32'h0);
        wr(4'd1, 8'h00);
        rd(4'd0, s);
        check("R3 resumed", 32'(s & 8'hC4), 32'h80);
        ngot = 0;
        collect(64);
        check("R3 total words", 32'(ngot), 32'd12);
        check_seq("R3 order", 0, 32'h3000, 12);
        wr(4'd0, 8'h07);

        // R7 auto-restart, then R9 kill
        wr(4'd2, 8'h80);
        set_desc(0, 32'h4000, 24'd8, F_EOL);
        ngot = 0;
        wr(4'd1, 8'h80);
        collect(6);
        for (int i = 0; i < 6; i++)
            check("R7 auto-restart replay", got[i], pat(32'h4000 + 32'(4 * (i % 2))));
        rd(4'd0, s);
        check("R7 active with EOL seen", 32'(s & 8'h82), 32'h82);
        wr(4'd1, 8'h40);
        rd(4'd0, s);
        check("R9 kill clears active", 32'(s & 8'h88), 32'h00);
        ngot = 0;
        collect(64);
        wr(4'd0, 8'h07);
        wr(4'd2, 8'h00);

        // R8 queued trigger replays the table once
        set_desc(0, 32'h5000, 24'd16, F_EOL);
        ngot = 0;
        wr(4'd1, 8'h80);
        wr(4'd1, 8'h80);
        rd(4'd0, s);
        check("R8 trigger queued", 32'(s & 8'h88), 32'h88);
        collect(64);
        check("R8 two passes", 32'(ngot), 32'd8);
        check_seq("R8 first pass", 0, 32'h5000, 4);
        check_seq("R8 second pass", 4, 32'h5000, 4);
        rd(4'd0, s);
        check("R8 queue consumed", 32'(s), 32'h02);
        wr(4'd0, 8'h07);

        // R9 kill clears queued trigger too
        wr(4'd1, 8'h80);
        wr(4'd1, 8'h80);
        wr(4'd1, 8'h40);
        rd(4'd0, s);
        check("R9 kill clears queue", 32'(s & 8'h88), 32'h00);
        ngot = 0;
        collect(64);

        check("R13 request hold violations", 32'(r13_err), 32'd0);
        summary_and_end();
    end
endmodule